// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Selectable Write Read-Back

This block is a synchronous memory with two independent access ports, A and B. Each port has its own enable, address, write data, per-lane write enables and registered read data, and both ports may read or write in the same cycle. The word is split into byte lanes. Each lane holds eight data bits plus one parity bit, and one write enable covers the whole lane. The block stores the parity bit like any other bit and does not compute or check it.

A write cycle also updates the port's read data. A per-port parameter chooses what that data is. In read-first mode the port returns the word stored before the write. In write-first mode it returns the word as it stands after the write, so lanes that were not written show their stored contents. In no-change mode the port keeps its previous output. A per-port parameter can add an output pipeline register, which adds one cycle of read latency.

Both ports are sampled on one shared clock edge. If both ports are enabled on the same address and at least one of them writes, the data involved is undefined. The block raises a collision flag for that cycle.

Top module: `tdp_byte_ram`

## Requirements
- R1: While reset is asserted and right after it is released, both read data outputs and the collision flag are zero.
- R2: A port that is enabled with all write enables low presents the stored word at its address on its read data one clock edge later, when its pipeline option is off.
- R3: Write enable bit k (bit 0 is the least significant lane) writes word bits [9k+8:9k], including the parity bit at 9k+8, and leaves all other lanes of that word unchanged.
- R4: In read-first mode, a write cycle presents the word stored before the write.
- R5: In write-first mode, a write cycle presents the word after the write: written lanes carry the new data and unwritten lanes carry the stored data.
- R6: In no-change mode, a write cycle leaves the port's read data unchanged.
- R7: While a port's enable is low, that port writes nothing and its read data holds.
- R8: With the pipeline option on, every read data value appears one cycle later than it does with the option off.
- R9: The two ports operate independently. When they use different addresses in the same cycle, each one reads and writes as if the other were idle, and a word written by one port can be read back through the other.
- R10: The collision flag is high one edge after a cycle in which both ports are enabled on the same address and at least one of them writes. It is low one edge after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | LANES | Port A lane write enables |
| a_addr | input | AW | Port A word address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_rdata | output | LANES*LANE_W | Port A read data |
| b_en | input | 1 | Port B enable |
| b_we | input | LANES | Port B lane write enables |
| b_addr | input | AW | Port B word address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_rdata | output | LANES*LANE_W | Port B read data |
| collision | output | 1 | Same-address conflict seen at the previous edge |

## Verification
The bound checker checks the following on every cycle. A port with its enable low holds its output. A no-change port holds its output across a write. A write-first port echoes a full-word write. The collision flag rises and clears according to the enables, addresses and write enables one edge earlier. Only the bench scenarios can show that stored contents are correct: which lanes a partial write leaves untouched, what read-first returns, data crossing from one port to the other, and the exact extra cycle of the pipeline option. The bench covers these by running one stimulus stream through a reference memory and comparing all four port variants against it.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;

   // What a port's read data shows during a write cycle.
   typedef enum logic [1:0] {
      WM_READ_FIRST  = 2'd0,
      WM_WRITE_FIRST = 2'd1,
      WM_NO_CHANGE   = 2'd2
   } wr_mode_e;

endpackage

// File: rtl/tdp_ram_array.sv
module tdp_ram_array #(
   parameter int DEPTH  = 1024,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int WW    = LANES * LANE_W,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             a_en,
   input  logic [LANES-1:0] a_we,
   input  logic [AW-1:0]    a_addr,
   input  logic [WW-1:0]    a_wdata,
   output logic [WW-1:0]    a_old,
   input  logic             b_en,
   input  logic [LANES-1:0] b_we,
   input  logic [AW-1:0]    b_addr,
   input  logic [WW-1:0]    b_wdata,
   output logic [WW-1:0]    b_old
);

   logic [WW-1:0] mem [DEPTH];

   // Contents seen before this edge's writes.
   assign a_old = mem[a_addr];
   assign b_old = mem[b_addr];

   // One process updates the array, so the order of two writes to the same
   // lane is fixed (port B lands last). The requirements still treat that case as undefined.
   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (a_en && a_we[l]) mem[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
      end
      for (int l = 0; l < LANES; l++) begin
         if (b_en && b_we[l]) mem[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
      end
   end

endmodule

// File: rtl/tdp_ram_port_out.sv
module tdp_ram_port_out
   import tdp_ram_pkg::*;
#(
   parameter wr_mode_e MODE  = WM_READ_FIRST,
   parameter int PIPE        = 0,
   parameter int LANES       = 4,
   parameter int LANE_W      = 9,
   localparam int WW         = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LANES-1:0] we,
   input  logic [WW-1:0]    wdata,
   input  logic [WW-1:0]    old,
   output logic [WW-1:0]    rdata
);

   logic [WW-1:0] merged;
   logic [WW-1:0] nxt;
   logic          load;
   logic [WW-1:0] stage_q;

   // Word as it will stand after this edge: new lanes over stored ones.
   always_comb begin
      merged = old;
      for (int l = 0; l < LANES; l++) begin
         if (we[l]) merged[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
      end
   end

   generate
      if (MODE == WM_WRITE_FIRST) begin : g_wf
         assign load = en;
         assign nxt  = merged;
      end else if (MODE == WM_NO_CHANGE) begin : g_nc
         assign load = en && (we == '0);
         assign nxt  = old;
      end else begin : g_rf
         assign load = en;
         assign nxt  = old;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    stage_q <= '0;
      else if (load) stage_q <= nxt;
   end

   generate
      if (PIPE != 0) begin : g_pipe
         logic [WW-1:0] pipe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= stage_q;
         end
         assign rdata = pipe_q;
      end else begin : g_direct
         assign rdata = stage_q;
      end
   endgenerate

endmodule

// File: rtl/tdp_ram_collide.sv
module tdp_ram_collide #(
   parameter int AW    = 10,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_en,
   input  logic [LANES-1:0] a_we,
   input  logic [AW-1:0]    a_addr,
   input  logic             b_en,
   input  logic [LANES-1:0] b_we,
   input  logic [AW-1:0]    b_addr,
   output logic             collision
);

   logic same_word;
   logic any_write;
   logic hit;

   assign same_word = a_en && b_en && (a_addr == b_addr);
   assign any_write = (a_we != '0) || (b_we != '0);
   assign hit       = same_word && any_write;

   // Registered so the flag lines up with the unpipelined read data.
   always_ff @(posedge clk) begin
      if (!rst_n) collision <= 1'b0;
      else        collision <= hit;
   end

endmodule

// File: rtl/tdp_byte_ram.sv
module tdp_byte_ram
   import tdp_ram_pkg::*;
#(
   parameter int DEPTH      = 1024,
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   parameter wr_mode_e MODE_A = WM_READ_FIRST,
   parameter wr_mode_e MODE_B = WM_READ_FIRST,
   parameter int PIPE_A     = 0,
   parameter int PIPE_B     = 0,
   localparam int WW        = LANES * LANE_W,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_en,
   input  logic [LANES-1:0] a_we,
   input  logic [AW-1:0]    a_addr,
   input  logic [WW-1:0]    a_wdata,
   output logic [WW-1:0]    a_rdata,
   input  logic             b_en,
   input  logic [LANES-1:0] b_we,
   input  logic [AW-1:0]    b_addr,
   input  logic [WW-1:0]    b_wdata,
   output logic [WW-1:0]    b_rdata,
   output logic             collision
);

   // Elaboration-time parameter checks.
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("tdp_byte_ram: DEPTH must be a power of two of at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("tdp_byte_ram: LANES must be at least 1");
   end
   if (LANE_W < 2) begin : g_bad_lane_w
      $error("tdp_byte_ram: LANE_W must hold data plus a parity bit");
   end
   if (PIPE_A < 0 || PIPE_A > 1 || PIPE_B < 0 || PIPE_B > 1) begin : g_bad_pipe
      $error("tdp_byte_ram: PIPE_A and PIPE_B take 0 or 1");
   end

   logic [WW-1:0] a_old;
   logic [WW-1:0] b_old;

   tdp_ram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) array_i (
      .clk     (clk),
      .a_en    (a_en),
      .a_we    (a_we),
      .a_addr  (a_addr),
      .a_wdata (a_wdata),
      .a_old   (a_old),
      .b_en    (b_en),
      .b_we    (b_we),
      .b_addr  (b_addr),
      .b_wdata (b_wdata),
      .b_old   (b_old)
   );

   tdp_ram_port_out #(.MODE(MODE_A), .PIPE(PIPE_A), .LANES(LANES), .LANE_W(LANE_W)) port_a_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (a_en),
      .we    (a_we),
      .wdata (a_wdata),
      .old   (a_old),
      .rdata (a_rdata)
   );

   tdp_ram_port_out #(.MODE(MODE_B), .PIPE(PIPE_B), .LANES(LANES), .LANE_W(LANE_W)) port_b_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (b_en),
      .we    (b_we),
      .wdata (b_wdata),
      .old   (b_old),
      .rdata (b_rdata)
   );

   tdp_ram_collide #(.AW(AW), .LANES(LANES)) collide_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_en      (a_en),
      .a_we      (a_we),
      .a_addr    (a_addr),
      .b_en      (b_en),
      .b_we      (b_we),
      .b_addr    (b_addr),
      .collision (collision)
   );

endmodule

// File: rtl/tdp_byte_ram_chk.sv
module tdp_byte_ram_chk
   import tdp_ram_pkg::*;
#(
   parameter int LANES        = 4,
   parameter int WW           = 36,
   parameter int AW           = 10,
   parameter wr_mode_e MODE_A = WM_READ_FIRST,
   parameter wr_mode_e MODE_B = WM_READ_FIRST,
   parameter int PIPE_A       = 0,
   parameter int PIPE_B       = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             a_en,
   input logic [LANES-1:0] a_we,
   input logic [AW-1:0]    a_addr,
   input logic [WW-1:0]    a_wdata,
   input logic [WW-1:0]    a_rdata,
   input logic             b_en,
   input logic [LANES-1:0] b_we,
   input logic [AW-1:0]    b_addr,
   input logic [WW-1:0]    b_wdata,
   input logic [WW-1:0]    b_rdata,
   input logic             collision
);

   // R10: flag rises after a same-address cycle that includes a write.
   assert_collide_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && b_en && a_addr == b_addr && (a_we != '0 || b_we != '0)) |=> collision);

   // R10: flag is low after a cycle in which one of the ports is idle.
   assert_collide_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_en || !b_en) |=> !collision);

   generate
      if (PIPE_A == 0) begin : g_a0
         assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !a_en |=> $stable(a_rdata));
         if (MODE_A == WM_NO_CHANGE) begin : g_nc
            assert_nochange_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (a_en && a_we != '0) |=> $stable(a_rdata));
         end
         if (MODE_A == WM_WRITE_FIRST) begin : g_wf
            assert_wfirst_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (a_en && (&a_we)) |=> a_rdata == $past(a_wdata));
         end
      end else begin : g_a1
         assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !a_en |=> ##1 $stable(a_rdata));
         if (MODE_A == WM_NO_CHANGE) begin : g_nc
            assert_nochange_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (a_en && a_we != '0) |=> ##1 $stable(a_rdata));
         end
         if (MODE_A == WM_WRITE_FIRST) begin : g_wf
            assert_wfirst_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
               (a_en && (&a_we)) |=> ##1 a_rdata == $past(a_wdata, 2));
         end
      end
      if (PIPE_B == 0) begin : g_b0
         assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !b_en |=> $stable(b_rdata));
         if (MODE_B == WM_NO_CHANGE) begin : g_nc
            assert_nochange_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (b_en && b_we != '0) |=> $stable(b_rdata));
         end
         if (MODE_B == WM_WRITE_FIRST) begin : g_wf
            assert_wfirst_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (b_en && (&b_we)) |=> b_rdata == $past(b_wdata));
         end
      end else begin : g_b1
         assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !b_en |=> ##1 $stable(b_rdata));
         if (MODE_B == WM_NO_CHANGE) begin : g_nc
            assert_nochange_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (b_en && b_we != '0) |=> ##1 $stable(b_rdata));
         end
         if (MODE_B == WM_WRITE_FIRST) begin : g_wf
            assert_wfirst_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
               (b_en && (&b_we)) |=> ##1 b_rdata == $past(b_wdata, 2));
         end
      end
   endgenerate

endmodule

bind tdp_byte_ram tdp_byte_ram_chk #(
   .LANES  (LANES),
   .WW     (WW),
   .AW     (AW),
   .MODE_A (MODE_A),
   .MODE_B (MODE_B),
   .PIPE_A (PIPE_A),
   .PIPE_B (PIPE_B)
) chk_i (.*);

// File: tb/tdp_byte_ram_tb_top.sv
module tdp_byte_ram_tb_top;
   import tdp_ram_pkg::*;

   localparam int DEPTH = 1024;
   localparam int LANES = 4;
   localparam int LW    = 9;
   localparam int WW    = LANES * LW;
   localparam int AW    = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic             a_en = 0, b_en = 0;
   logic [LANES-1:0] a_we = '0, b_we = '0;
   logic [AW-1:0]    a_addr = '0, b_addr = '0;
   logic [WW-1:0]    a_wdata = '0, b_wdata = '0;
   logic [WW-1:0]    rd [4];
   logic             col [2];

   // Port variants: 0 write-first/direct, 1 read-first/piped,
   // 2 no-change/direct, 3 write-first/piped.
   tdp_byte_ram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LW),
      .MODE_A(WM_WRITE_FIRST), .PIPE_A(0), .MODE_B(WM_READ_FIRST), .PIPE_B(1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(rd[0]),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rd[1]),
      .collision(col[0]));

   tdp_byte_ram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LW),
      .MODE_A(WM_NO_CHANGE), .PIPE_A(0), .MODE_B(WM_WRITE_FIRST), .PIPE_B(1)) dut2_i (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(rd[2]),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rd[3]),
      .collision(col[1]));

   wr_mode_e      pm [4] = '{WM_WRITE_FIRST, WM_READ_FIRST, WM_NO_CHANGE, WM_WRITE_FIRST};
   int            pp [4] = '{0, 1, 0, 1};
   logic [WW-1:0] s1 [4] = '{default: '0};
   bit            unk [4] = '{default: 1'b0};
   logic [WW-1:0] mref [DEPTH];
   bit            kn [DEPTH];
   bit            part [DEPTH];

   typedef struct {int due; logic [WW-1:0] val; string tag;} exp_t;
   exp_t q [4][$];
   exp_t cq [$];

   int cyc = 0;
   int total = 0;
   int fails = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tg, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tg, act, exp, cyc);
      end
   endtask

   function automatic logic [WW-1:0] pat(input int i);
      logic [WW-1:0] v;
      v = WW'(i) * 36'h1_2345_6789;
      return v ^ 36'h8_0402_0100;
   endfunction

   // Driver: applies one cycle of stimulus and predicts every port.
   task automatic step(input logic ae, input logic [LANES-1:0] aw, input logic [AW-1:0] aa,
                       input logic [WW-1:0] ad, input logic be, input logic [LANES-1:0] bw,
                       input logic [AW-1:0] ba, input logic [WW-1:0] bd);
      logic coll;
      bit   indep;
      logic [WW-1:0] oldv [2];
      bit   oldk [2];
      bit   oldp [2];
      @(negedge clk);
      a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
      b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
      coll  = ae && be && (aa == ba) && (aw != '0 || bw != '0);
      indep = ae && be && (aa != ba);
      cq.push_back('{cyc + 1, {35'd0, coll}, "R10"});
      oldv[0] = mref[aa]; oldk[0] = kn[aa]; oldp[0] = part[aa];
      oldv[1] = mref[ba]; oldk[1] = kn[ba]; oldp[1] = part[ba];
      for (int p = 0; p < 4; p++) begin
         int s = p % 2;
         logic en;
         logic [LANES-1:0] we;
         logic [WW-1:0] wd, nv;
         string tg;
         bit ld, need;
         en = s ? be : ae; we = s ? bw : aw; wd = s ? bd : ad;
         ld = 0; need = 1; nv = oldv[s];
         if (!en) tg = "R7";
         else if (we == '0) begin ld = 1; tg = oldp[s] ? "R3" : "R2"; end
         else if (pm[p] == WM_READ_FIRST) begin ld = 1; tg = "R4"; end
         else if (pm[p] == WM_WRITE_FIRST) begin
            ld = 1; tg = "R5"; need = (we != '1);
            for (int l = 0; l < LANES; l++) if (we[l]) nv[l*LW +: LW] = wd[l*LW +: LW];
         end else tg = "R6";
         if (indep) tg = {tg, "/R9"};
         if (pp[p] != 0) tg = {tg, "/R8"};
         if (ld) begin
            s1[p]  = nv;
            unk[p] = (need && !oldk[s]) || coll;
         end
         if (!unk[p]) q[p].push_back('{cyc + 1 + pp[p], s1[p], tg});
      end
      for (int s = 0; s < 2; s++) begin
         logic en;
         logic [LANES-1:0] we;
         logic [AW-1:0] ad2;
         logic [WW-1:0] wd;
         en = s ? be : ae; we = s ? bw : aw; ad2 = s ? ba : aa; wd = s ? bd : ad;
         if (en && we != '0) begin
            for (int l = 0; l < LANES; l++) if (we[l]) mref[ad2][l*LW +: LW] = wd[l*LW +: LW];
            kn[ad2]   = (kn[ad2] || we == '1) && !coll;
            part[ad2] = (we != '1);
         end
      end
   endtask

   // Monitor: compares outputs against predictions as they fall due.
   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < 4; p++) begin
            while (q[p].size() > 0 && q[p][0].due <= cyc) begin
               exp_t it;
               it = q[p].pop_front();
               chk(it.due == cyc && rd[p] === it.val, $sformatf("%s port%0d", it.tag, p), rd[p], it.val);
            end
         end
         while (cq.size() > 0 && cq[0].due <= cyc) begin
            exp_t it;
            it = cq.pop_front();
            for (int d = 0; d < 2; d++)
               chk(it.due == cyc && col[d] === it.val[0], $sformatf("R10 flag%0d", d),
                   {35'd0, col[d]}, it.val);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog R1-flow: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int seed;
      for (int i = 0; i < DEPTH; i++) begin kn[i] = 0; part[i] = 0; mref[i] = '0; end
      repeat (3) @(negedge clk);
      // R1: outputs during reset.
      for (int p = 0; p < 4; p++) chk(rd[p] === '0, "R1 reset rdata", rd[p], '0);
      chk(col[0] === 1'b0 && col[1] === 1'b0, "R1 reset collision", {34'd0, col[1], col[0]}, '0);
      rst_n = 1'b1;
      // Fill words 0..15 through A and 16..31 through B at the same time.
      for (int i = 0; i < 16; i++) step(1, '1, AW'(i), pat(i), 1, '1, AW'(16 + i), pat(100 + i));
      // Cross reads: each port reads what the other wrote.
      for (int i = 0; i < 16; i++) step(1, '0, AW'(16 + i), '0, 1, '0, AW'(i), '0);
      // R3: partial lane writes, parity bits included, then read back.
      step(1, 4'b0101, 3, 36'hF_FFFF_FFFF, 1, 4'b1010, 20, 36'h8_0402_0100);
      step(1, 4'b1000, 5, 36'hA_AAAA_AAAA, 1, 4'b0001, 21, 36'h1_5555_5555);
      step(1, '0, 3, '0, 1, '0, 20, '0);
      step(1, '0, 5, '0, 1, '0, 21, '0);
      step(1, '0, 20, '0, 1, '0, 3, '0);
      // R7: enables low with writes requested, then confirm nothing changed.
      step(0, '1, 7, pat(300), 0, '1, 8, pat(301));
      step(0, '1, 7, pat(302), 0, '1, 8, pat(303));
      step(1, '0, 7, '0, 1, '0, 8, '0);
      // Top and bottom of the address range.
      step(1, '1, AW'(DEPTH - 1), pat(400), 1, '1, 0, pat(401));
      step(1, '0, 0, '0, 1, '0, AW'(DEPTH - 1), '0);
      // R10: same-address cycles.
      step(1, '1, 9, pat(500), 1, '0, 9, '0);
      step(1, '0, 9, '0, 1, '0, 9, '0);
      step(1, 4'b0011, 10, pat(501), 1, 4'b1100, 10, pat(502));
      step(1, '1, 9, pat(503), 0, '0, 0, '0);
      step(1, '1, 10, pat(504), 1, '0, 9, '0);
      step(1, '0, 10, '0, 1, '0, 10, '0);
      // Mixed traffic over words 0..31.
      seed = 12345;
      for (int i = 0; i < 200; i++) begin
         logic [31:0] r;
         seed = seed * 1103515245 + 12345;
         r = seed;
         step(r[0], r[1] ? r[5:2] : 4'b0000, AW'(r[10:6]), pat(600 + i),
              r[11], r[12] ? r[16:13] : 4'b0000, AW'(r[21:17]), pat(900 + i));
      end
      repeat (4) step(0, '0, 0, '0, 0, '0, 0, '0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule